// File: doc/BRIEF.md
# Bus-Configurable Four-Bit Datapath

This block is a small register-to-register datapath: a four-entry, four-bit register file, an arithmetic/logic unit with an operand holding latch, and an end-around rotate stage on the ALU output. A single command carries two source register indices, a destination index, an ALU operation, a rotate amount and a four-bit immediate. The block carries out the operation and writes the rotated result back into the destination register.

A build-time parameter sets how many internal buses join the register file to the ALU. With one bus, the two operands travel one after the other. The first is parked in the operand latch, the second is combined with it, and the result is rotated and written in a third cycle. With two buses both operands arrive together, and the write follows one cycle later. With three buses the whole read, compute, rotate and write sequence completes in the clock period in which the command is taken.

A small sequencer takes a command only when it is idle and holds a busy flag while the operation is in flight. When the write happens it pulses a done strobe and presents the written value and the ALU carry.

Top module: `nib_datapath`

## Requirements
- R1: While reset is asserted all four registers clear to zero and the sequencer returns to idle. After reset, busy, done, res_data and res_carry read 0, and every register reads back as 0.
- R2: A command is taken on a rising clock edge only when cmd_valid is high and the sequencer is idle. A command offered while busy is high is dropped: it causes no done pulse and no register write.
- R3: If a command is taken at edge k, done is high for exactly one cycle, the cycle after edge k+3-BUS_COUNT. busy is high in every cycle between acceptance and that done cycle and low in the done cycle. With BUS_COUNT=3, busy never rises.
- R4: cmd_op selects the ALU function: 0 is A+B with res_carry equal to bit 4 of the five-bit sum, 1 passes A, 2 is A XOR B, and 3 returns cmd_imm. res_carry is 0 for every operation other than 0.
- R5: The ALU output is rotated left, end-around, by cmd_rot (0 to 3). Output bit i takes input bit (i - cmd_rot) mod 4, so 4'b0001 rotated by 1 gives 4'b0010 and 4'b1000 rotated by 3 gives 4'b0100.
- R6: The rotated result is written into register cmd_dst and appears on res_data, with the carry on res_carry, in the done cycle. Both outputs hold that value until the next done pulse.
- R7: The operands are the register contents as they stand when the operation reads them. A source may equal the other source or the destination, and such an operation uses the old value and overwrites it with the new one.
- R8: With BUS_COUNT=1 the first operand is captured into the operand latch at the accepting edge and the second is read over the same bus one cycle later. With BUS_COUNT=2 both are read at the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_src_a | input | 2 | Register index of operand A |
| cmd_src_b | input | 2 | Register index of operand B |
| cmd_dst | input | 2 | Register index written with the result |
| cmd_op | input | 2 | ALU function: 0 add, 1 pass A, 2 xor, 3 immediate |
| cmd_rot | input | 2 | Left rotate amount, 0 to 3 |
| cmd_imm | input | 4 | Immediate value used by function 3 |
| busy | output | 1 | Operation in flight; new commands are dropped |
| done | output | 1 | One-cycle pulse in the cycle after the write-back edge |
| res_data | output | 4 | Value written by the last completed operation |
| res_carry | output | 1 | ALU carry of the last completed operation |

## Verification
A wrong staging step would show up on res_data in the done cycle of the affected command. For example, an operand latched one cycle late, or the second operand taken from the wrong bus. A later read-back of the destination register would expose it again. A sequencer that stalls, skips a phase or accepts a command while busy moves or duplicates the done pulse. That is visible within at most three cycles of the acceptance edge. All three bus variants run side by side on identical commands, so a fault confined to one variant's staging differs at once from the shared expected value.

// File: rtl/dp_pkg.sv
package dp_pkg;

    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_PASS = 2'd1,
        OP_XOR  = 2'd2,
        OP_IMM  = 2'd3
    } dp_op_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_OPA  = 2'd1,
        PH_RES  = 2'd2
    } dp_phase_e;

endpackage

// File: rtl/dp_regfile.sv
module dp_regfile #(
    parameter int WIDTH    = 4,
    parameter int NUM_REGS = 4,
    parameter int AW       = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    rd0_addr,
    output logic [WIDTH-1:0] rd0_data,
    input  logic [AW-1:0]    rd1_addr,
    output logic [WIDTH-1:0] rd1_data,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data
);

    logic [WIDTH-1:0] mem_d [NUM_REGS];
    logic [WIDTH-1:0] mem_q [NUM_REGS];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_q <= '{default: '0};
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd0_data = mem_q[rd0_addr];
    assign rd1_data = mem_q[rd1_addr];

endmodule

// File: rtl/dp_alu.sv
module dp_alu
    import dp_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [WIDTH-1:0] imm,
    input  dp_op_e           op,
    output logic [WIDTH-1:0] result,
    output logic             carry
);

    logic [WIDTH:0] sum;

    always_comb begin
        sum    = {1'b0, opnd_a} + {1'b0, opnd_b};
        result = '0;
        carry  = 1'b0;
        unique case (op)
            OP_ADD: begin
                result = sum[WIDTH-1:0];
                carry  = sum[WIDTH];
            end
            OP_PASS: result = opnd_a;
            OP_XOR:  result = opnd_a ^ opnd_b;
            OP_IMM:  result = imm;
            default: result = '0;
        endcase
    end

endmodule

// File: rtl/dp_rotator.sv
module dp_rotator #(
    parameter int WIDTH = 4,
    parameter int SW    = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] din,
    input  logic [SW-1:0]    amt,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage [SW+1];

    assign stage[0] = din;

    for (genvar s = 0; s < SW; s++) begin : g_stage
        localparam int K = 1 << s;
        assign stage[s+1] = amt[s] ? {stage[s][WIDTH-K-1:0], stage[s][WIDTH-1:WIDTH-K]}
                                   : stage[s];
    end

    assign dout = stage[SW];

endmodule

// File: rtl/dp_sequencer.sv
module dp_sequencer
    import dp_pkg::*;
#(
    parameter int BUS_COUNT = 1,
    parameter int WIDTH     = 4,
    parameter int AW        = 2,
    parameter int SW        = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [AW-1:0]    cmd_src_a,
    input  logic [AW-1:0]    cmd_src_b,
    input  logic [AW-1:0]    cmd_dst,
    input  dp_op_e           cmd_op,
    input  logic [SW-1:0]    cmd_rot,
    input  logic [WIDTH-1:0] cmd_imm,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] res_data,
    output logic             res_carry,
    output logic [AW-1:0]    rd0_addr,
    input  logic [WIDTH-1:0] rd0_data,
    output logic [AW-1:0]    rd1_addr,
    input  logic [WIDTH-1:0] rd1_data,
    output logic [WIDTH-1:0] alu_a,
    output logic [WIDTH-1:0] alu_b,
    output logic [WIDTH-1:0] alu_imm,
    output dp_op_e           alu_op,
    input  logic [WIDTH-1:0] alu_res,
    input  logic             alu_carry,
    output logic [WIDTH-1:0] rot_in,
    output logic [SW-1:0]    rot_amt,
    input  logic [WIDTH-1:0] rot_out,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic [WIDTH-1:0] wr_data
);

    localparam bit ONE_BUS   = (BUS_COUNT == 1);
    localparam bit TWO_BUS   = (BUS_COUNT == 2);

    typedef struct packed {
        dp_phase_e        phase;
        logic [AW-1:0]    src_b;
        logic [AW-1:0]    dst;
        dp_op_e           op;
        logic [SW-1:0]    rot;
        logic [WIDTH-1:0] imm;
        logic [WIDTH-1:0] opa;
        logic [WIDTH-1:0] res;
        logic             carry;
        logic             done;
        logic [WIDTH-1:0] out_data;
        logic             out_carry;
    } seq_t;

    seq_t st_d, st_q;

    logic [WIDTH-1:0] bus_a;
    logic [WIDTH-1:0] bus_b;
    logic             accept;

    // With a single bus both operands share read port 0 in turn.
    assign bus_a  = rd0_data;
    assign bus_b  = ONE_BUS ? rd0_data : rd1_data;
    assign accept = cmd_valid && (st_q.phase == PH_IDLE);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;

        rd0_addr = cmd_src_a;
        rd1_addr = cmd_src_b;
        alu_a    = bus_a;
        alu_b    = bus_b;
        alu_op   = cmd_op;
        alu_imm  = cmd_imm;
        rot_in   = alu_res;
        rot_amt  = cmd_rot;
        wr_en    = 1'b0;
        wr_addr  = cmd_dst;
        wr_data  = rot_out;

        unique case (st_q.phase)
            PH_IDLE: begin
                if (accept) begin
                    st_d.src_b = cmd_src_b;
                    st_d.dst   = cmd_dst;
                    st_d.op    = cmd_op;
                    st_d.rot   = cmd_rot;
                    st_d.imm   = cmd_imm;
                    if (ONE_BUS) begin
                        st_d.opa   = bus_a;
                        st_d.phase = PH_OPA;
                    end else if (TWO_BUS) begin
                        st_d.res   = alu_res;
                        st_d.carry = alu_carry;
                        st_d.phase = PH_RES;
                    end else begin
                        wr_en          = 1'b1;
                        st_d.done      = 1'b1;
                        st_d.out_data  = rot_out;
                        st_d.out_carry = alu_carry;
                    end
                end
            end
            PH_OPA: begin
                rd0_addr   = st_q.src_b;
                alu_a      = st_q.opa;
                alu_op     = st_q.op;
                alu_imm    = st_q.imm;
                st_d.res   = alu_res;
                st_d.carry = alu_carry;
                st_d.phase = PH_RES;
            end
            PH_RES: begin
                rot_in         = st_q.res;
                rot_amt        = st_q.rot;
                wr_en          = 1'b1;
                wr_addr        = st_q.dst;
                st_d.done      = 1'b1;
                st_d.out_data  = rot_out;
                st_d.out_carry = st_q.carry;
                st_d.phase     = PH_IDLE;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy      = (st_q.phase != PH_IDLE);
    assign done      = st_q.done;
    assign res_data  = st_q.out_data;
    assign res_carry = st_q.out_carry;

endmodule

// File: rtl/nib_datapath.sv
module nib_datapath
    import dp_pkg::*;
#(
    parameter int BUS_COUNT = 1,
    parameter int WIDTH     = 4,
    parameter int NUM_REGS  = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cmd_valid,
    input  logic [$clog2(NUM_REGS)-1:0] cmd_src_a,
    input  logic [$clog2(NUM_REGS)-1:0] cmd_src_b,
    input  logic [$clog2(NUM_REGS)-1:0] cmd_dst,
    input  logic [1:0]                  cmd_op,
    input  logic [$clog2(WIDTH)-1:0]    cmd_rot,
    input  logic [WIDTH-1:0]            cmd_imm,
    output logic                        busy,
    output logic                        done,
    output logic [WIDTH-1:0]            res_data,
    output logic                        res_carry
);

    localparam int AW = $clog2(NUM_REGS);
    localparam int SW = $clog2(WIDTH);

    logic [AW-1:0]    rf_rd0_addr, rf_rd1_addr, rf_wr_addr;
    logic [WIDTH-1:0] rf_rd0_data, rf_rd1_data, rf_wr_data;
    logic             rf_wr_en;
    logic [WIDTH-1:0] alu_a, alu_b, alu_imm, alu_res;
    logic             alu_carry;
    dp_op_e           alu_op;
    logic [WIDTH-1:0] rot_in, rot_out;
    logic [SW-1:0]    rot_amt;

    dp_regfile #(.WIDTH(WIDTH), .NUM_REGS(NUM_REGS), .AW(AW)) u_regfile (
        .clk      (clk),
        .rst      (rst),
        .rd0_addr (rf_rd0_addr),
        .rd0_data (rf_rd0_data),
        .rd1_addr (rf_rd1_addr),
        .rd1_data (rf_rd1_data),
        .wr_en    (rf_wr_en),
        .wr_addr  (rf_wr_addr),
        .wr_data  (rf_wr_data)
    );

    dp_alu #(.WIDTH(WIDTH)) u_alu (
        .opnd_a (alu_a),
        .opnd_b (alu_b),
        .imm    (alu_imm),
        .op     (alu_op),
        .result (alu_res),
        .carry  (alu_carry)
    );

    dp_rotator #(.WIDTH(WIDTH), .SW(SW)) u_rotator (
        .din  (rot_in),
        .amt  (rot_amt),
        .dout (rot_out)
    );

    dp_sequencer #(.BUS_COUNT(BUS_COUNT), .WIDTH(WIDTH), .AW(AW), .SW(SW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_src_a (cmd_src_a),
        .cmd_src_b (cmd_src_b),
        .cmd_dst   (cmd_dst),
        .cmd_op    (dp_op_e'(cmd_op)),
        .cmd_rot   (cmd_rot),
        .cmd_imm   (cmd_imm),
        .busy      (busy),
        .done      (done),
        .res_data  (res_data),
        .res_carry (res_carry),
        .rd0_addr  (rf_rd0_addr),
        .rd0_data  (rf_rd0_data),
        .rd1_addr  (rf_rd1_addr),
        .rd1_data  (rf_rd1_data),
        .alu_a     (alu_a),
        .alu_b     (alu_b),
        .alu_imm   (alu_imm),
        .alu_op    (alu_op),
        .alu_res   (alu_res),
        .alu_carry (alu_carry),
        .rot_in    (rot_in),
        .rot_amt   (rot_amt),
        .rot_out   (rot_out),
        .wr_en     (rf_wr_en),
        .wr_addr   (rf_wr_addr),
        .wr_data   (rf_wr_data)
    );

endmodule

// File: rtl/dp_checker.sv
module dp_checker #(
    parameter int BUS_COUNT = 1,
    parameter int WIDTH     = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             done,
    input logic [WIDTH-1:0] res_data,
    input logic             wr_en
);

    // R3: an operation in flight ends only through a done pulse
    busy_exit_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> (busy || done));

    // R3: the done cycle is never a busy cycle
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R6: the presented result changes only together with done
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(res_data));

    // R6: every register write is followed by a done pulse
    write_done_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> done);

    if (BUS_COUNT == 3) begin : g_single
        // R3: the three-bus variant never enters a busy cycle
        never_busy_chk: assert property (@(posedge clk) disable iff (rst)
            !busy);
    end else begin : g_multi
        // R3: multi-cycle variants pass through busy before done
        done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
            done |-> $past(busy));
    end

    if (BUS_COUNT == 1) begin : g_one
        // R8: the one-bus variant stays busy for two consecutive cycles
        two_busy_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(busy) |=> busy);
    end

endmodule

bind nib_datapath dp_checker #(.BUS_COUNT(BUS_COUNT), .WIDTH(WIDTH)) u_dp_checker (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .res_data (res_data),
    .wr_en    (rf_wr_en)
);

// File: tb/test_nib_datapath.sv
module test_nib_datapath;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [2:0] vld;
    logic [1:0] src_a, src_b, dst, op, rot;
    logic [3:0] imm;
    logic       busy_w  [3];
    logic       done_w  [3];
    logic [3:0] resd_w  [3];
    logic       resc_w  [3];

    int errors = 0;
    int checks = 0;
    logic [3:0] model [4];
    bit finished = 0;

    for (genvar b = 0; b < 3; b++) begin : g_bus
        nib_datapath #(.BUS_COUNT(b + 1)) i_nib_datapath (
            .clk       (clk),
            .rst       (rst),
            .cmd_valid (vld[b]),
            .cmd_src_a (src_a),
            .cmd_src_b (src_b),
            .cmd_dst   (dst),
            .cmd_op    (op),
            .cmd_rot   (rot),
            .cmd_imm   (imm),
            .busy      (busy_w[b]),
            .done      (done_w[b]),
            .res_data  (resd_w[b]),
            .res_carry (resc_w[b])
        );
    end

    function automatic logic [4:0] alu_ref(logic [1:0] f, logic [3:0] a, logic [3:0] bb, logic [3:0] im);
        logic [4:0] s;
        s = {1'b0, a} + {1'b0, bb};
        case (f)
            2'd0:    return s;
            2'd1:    return {1'b0, a};
            2'd2:    return {1'b0, a ^ bb};
            default: return {1'b0, im};
        endcase
    endfunction

    function automatic logic [3:0] rotl(logic [3:0] v, logic [1:0] r);
        logic [7:0] t;
        t = {v, v} << r;
        return t[7:4];
    endfunction

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Issue one command to all three variants and follow each one's timing.
    task automatic issue(logic [1:0] sa, logic [1:0] sb, logic [1:0] d, logic [1:0] f,
                         logic [1:0] r, logic [3:0] im, bit inject, string tag);
        logic [4:0] ar;
        logic [3:0] ev;
        logic       ec;
        ar = alu_ref(f, model[sa], model[sb], im);
        ev = rotl(ar[3:0], r);
        ec = ar[4];
        @(negedge clk);
        src_a = sa; src_b = sb; dst = d; op = f; rot = r; imm = im;
        vld = 3'b111;
        @(posedge clk);
        @(negedge clk);
        vld = 3'b000;
        if (inject) begin
            // R2: offer a different command to the variants that are still busy
            src_a = sa; src_b = sb; dst = d + 2'd1; op = 2'd3; imm = ~im; rot = 2'd0;
            vld = 3'b011;
        end
        for (int t = 1; t <= 3; t++) begin
            if (t == 2) vld = 3'b000;
            for (int b = 0; b < 3; b++) begin
                bit exp_done;
                bit exp_busy;
                exp_done = (t == 3 - b);
                exp_busy = (t < 3 - b);
                chk(done_w[b] == exp_done && busy_w[b] == exp_busy, "R3",
                    $sformatf("bus%0d t%0d done/busy", b + 1, t),
                    {done_w[b], busy_w[b]}, {exp_done, exp_busy});
                if (exp_done) begin
                    chk(resd_w[b] == ev, tag, $sformatf("bus%0d res_data", b + 1), resd_w[b], ev);
                    chk(resc_w[b] == ec, tag, $sformatf("bus%0d res_carry", b + 1), resc_w[b], ec);
                end
            end
            if (t < 3) @(negedge clk);
        end
        @(negedge clk);
        for (int b = 0; b < 3; b++) begin
            chk(done_w[b] == 1'b0 && busy_w[b] == 1'b0, inject ? "R2" : "R3",
                $sformatf("bus%0d quiet after done", b + 1), {done_w[b], busy_w[b]}, 0);
            chk(resd_w[b] == ev && resc_w[b] == ec, "R6",
                $sformatf("bus%0d result held", b + 1), {resc_w[b], resd_w[b]}, {ec, ev});
        end
        model[d] = ev;
    endtask

    // Read a register back by passing it onto itself with no rotation.
    task automatic readback(logic [1:0] r, string tag);
        issue(r, r, r, 2'd1, 2'd0, 4'd0, 1'b0, tag);
    endtask

    initial begin
        vld = '0; src_a = '0; src_b = '0; dst = '0; op = '0; rot = '0; imm = '0;
        for (int i = 0; i < 4; i++) model[i] = 4'd0;
        void'($urandom(32'd7321));
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int b = 0; b < 3; b++) begin
            chk(busy_w[b] == 0 && done_w[b] == 0, "R1", $sformatf("bus%0d flags in reset", b + 1),
                {busy_w[b], done_w[b]}, 0);
        end
        rst = 1'b0;
        @(negedge clk);
        for (int b = 0; b < 3; b++) begin
            chk(resd_w[b] == 0 && resc_w[b] == 0, "R1", $sformatf("bus%0d outputs after reset", b + 1),
                {resc_w[b], resd_w[b]}, 0);
        end
        for (int i = 0; i < 4; i++) readback(i[1:0], "R1");

        // R5: rotation corners
        issue(2'd0, 2'd0, 2'd0, 2'd3, 2'd1, 4'b0001, 1'b0, "R5");
        issue(2'd0, 2'd0, 2'd1, 2'd3, 2'd3, 4'b1000, 1'b0, "R5");
        issue(2'd0, 2'd0, 2'd2, 2'd3, 2'd2, 4'b1011, 1'b0, "R5");
        issue(2'd0, 2'd0, 2'd3, 2'd3, 2'd0, 4'b1001, 1'b0, "R4");
        // R4: add with carry out (9 + 14 = 23 -> 7, carry 1)
        issue(2'd2, 2'd3, 2'd3, 2'd0, 2'd0, 4'd0, 1'b0, "R4");
        issue(2'd1, 2'd2, 2'd0, 2'd2, 2'd0, 4'd0, 1'b0, "R4");
        issue(2'd2, 2'd1, 2'd1, 2'd1, 2'd1, 4'd5, 1'b0, "R4");
        // R7: source equals destination, same register used twice
        issue(2'd3, 2'd3, 2'd3, 2'd0, 2'd0, 4'd0, 1'b0, "R7");
        issue(2'd0, 2'd1, 2'd0, 2'd0, 2'd0, 4'd0, 1'b0, "R7");
        // R8: two distinct operands read in sequence over the single bus
        issue(2'd1, 2'd2, 2'd2, 2'd2, 2'd0, 4'd0, 1'b0, "R8");
        // R2: a command offered while busy is dropped
        issue(2'd0, 2'd1, 2'd1, 2'd0, 2'd1, 4'd3, 1'b1, "R2");
        readback(2'd2, "R2");
        for (int i = 0; i < 4; i++) readback(i[1:0], "R6");

        for (int n = 0; n < 60; n++) begin
            issue(2'($urandom), 2'($urandom), 2'($urandom), 2'($urandom),
                  2'($urandom), 4'($urandom), 1'($urandom), "R4");
        end
        for (int i = 0; i < 4; i++) readback(i[1:0], "R6");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule